// File: doc/BRIEF.md
# Transition Interface Ownership Mutex

This block decides which of two requesters may use a shared set of transition registers. One requester is a debug TAP, the other is the system bus. Each requester has its own 8-bit claim register. A requester gets ownership by writing the multi-bit true code to its claim register. Ownership then stays with that side until the same side releases it.

The owning side's write strobe, address and write data go through to the register set. The other side's write strobe is dropped. Read data from the register set goes back only to the owner. The non-owner reads zero, so token values cannot cross from one side to the other. A per-side write-enable status output tells software whether its writes can currently land. That status is cleared while a transition is in progress, and all writes into the register set are blocked during that time.

Top module: `trans_mutex`

## Requirements
- R1: After reset, nobody owns the mutex. Both claim readbacks return 8'h69, both write-enable status outputs are 0, `regWe` is 0, `regAddr` and `regWdata` are zero, and both read ports return zero.
- R2: While the mutex is free, a side that writes 8'h96 to its claim register becomes owner at the next clock edge. From then on its claim readback returns 8'h96, and its write-enable status is 1 while `transBusy` is 0.
- R3: While the mutex is free, a claim write of any value other than 8'h96 (including 8'h00, 8'h69 and all others) grants nothing. The mutex stays free and both write-enable status outputs stay 0.
- R4: If both sides write 8'h96 in the same cycle while the mutex is free, the TAP side becomes owner.
- R5: While one side owns the mutex, any claim write from the other side is ignored, and ownership does not change.
- R6: A claim write of any value other than 8'h96 by the owner releases the mutex at the next clock edge.
- R7: The owner's read port returns `regRdata`. The non-owner's read port returns zero.
- R8: `regWe` is 1 only when the owner asserts its write strobe. In that case `regAddr` and `regWdata` carry the owner's address and data. A write strobe from the non-owner gives `regWe` 0.
- R9: While `transBusy` is 1, `regWe` and both write-enable status outputs are 0, and ownership is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| transBusy | input | 1 | A transition is in progress |
| tapClaimWe | input | 1 | TAP side claim register write strobe |
| tapClaimWdata | input | 8 | TAP side claim write value |
| tapClaimRdata | output | 8 | TAP side claim readback (8'h96 when owner, else 8'h69) |
| tapRegwen | output | 1 | TAP side write-enable status |
| tapRegWe | input | 1 | TAP side transition register write strobe |
| tapRegAddr | input | ADDR_W | TAP side register address |
| tapRegWdata | input | DATA_W | TAP side register write data |
| tapRegRdata | output | DATA_W | TAP side masked read data |
| busClaimWe | input | 1 | Bus side claim register write strobe |
| busClaimWdata | input | 8 | Bus side claim write value |
| busClaimRdata | output | 8 | Bus side claim readback (8'h96 when owner, else 8'h69) |
| busRegwen | output | 1 | Bus side write-enable status |
| busRegWe | input | 1 | Bus side transition register write strobe |
| busRegAddr | input | ADDR_W | Bus side register address |
| busRegWdata | input | DATA_W | Bus side register write data |
| busRegRdata | output | DATA_W | Bus side masked read data |
| regWe | output | 1 | Gated write strobe to the register set |
| regAddr | output | ADDR_W | Owner's address to the register set |
| regWdata | output | DATA_W | Owner's write data to the register set |
| regRdata | input | DATA_W | Read data from the register set |

## Verification
Ownership is the only registered state. A claim write therefore shows up in the claim readback and the write-enable status one clock edge after it is presented. The bench drives each claim just after an edge and samples one nanosecond after the following edge. The gating and masking paths (`regWe`, `regAddr`, `regWdata`, the read ports, and the effect of `transBusy`) settle in the same cycle. The bench checks these with no clock edge in between, once the combinational paths have settled after the inputs change, so the state cannot move during the check.

// File: rtl/trans_mutex_pkg.sv
package trans_mutex_pkg;
  localparam int CLAIM_W = 8;
  localparam logic [CLAIM_W-1:0] CLAIM_TRUE  = 8'h96;
  localparam logic [CLAIM_W-1:0] CLAIM_FALSE = 8'h69;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_TAP  = 2'd1,
    OWN_BUS  = 2'd2
  } owner_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tapOwns;
    logic busOwns;
    logic writeOpen;
  } mutexStrobe_t;
endpackage

// File: rtl/trans_mutex_ctrl.sv
module trans_mutex_ctrl
  import trans_mutex_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               transBusy,
  input  logic               tapClaimWe,
  input  logic [CLAIM_W-1:0] tapClaimWdata,
  input  logic               busClaimWe,
  input  logic [CLAIM_W-1:0] busClaimWdata,
  output mutexStrobe_t       strobe,
  output logic [CLAIM_W-1:0] tapClaimRdata,
  output logic [CLAIM_W-1:0] busClaimRdata,
  output logic               tapRegwen,
  output logic               busRegwen
);
  owner_e ownerQ, ownerD;
  logic tapClaimTrue, busClaimTrue, tapDrop, busDrop;

  assign tapClaimTrue = tapClaimWe && (tapClaimWdata == CLAIM_TRUE);
  assign busClaimTrue = busClaimWe && (busClaimWdata == CLAIM_TRUE);
  assign tapDrop      = tapClaimWe && (tapClaimWdata != CLAIM_TRUE);
  assign busDrop      = busClaimWe && (busClaimWdata != CLAIM_TRUE);

  always_comb begin
    ownerD = ownerQ;
    unique case (ownerQ)
      OWN_NONE: begin
        if (tapClaimTrue)      ownerD = OWN_TAP;   // TAP has fixed priority
        else if (busClaimTrue) ownerD = OWN_BUS;
      end
      OWN_TAP: if (tapDrop) ownerD = OWN_NONE;
      OWN_BUS: if (busDrop) ownerD = OWN_NONE;
      default: ownerD = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ownerQ <= OWN_NONE;
    else       ownerQ <= ownerD;
  end

  assign strobe.tapOwns   = (ownerQ == OWN_TAP);
  assign strobe.busOwns   = (ownerQ == OWN_BUS);
  assign strobe.writeOpen = (ownerQ != OWN_NONE) && !transBusy;

  assign tapClaimRdata = strobe.tapOwns ? CLAIM_TRUE : CLAIM_FALSE;
  assign busClaimRdata = strobe.busOwns ? CLAIM_TRUE : CLAIM_FALSE;
  assign tapRegwen     = strobe.tapOwns && !transBusy;
  assign busRegwen     = strobe.busOwns && !transBusy;

  p_tap_priority_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ownerQ == OWN_NONE && tapClaimTrue) |=> (ownerQ == OWN_TAP));

  p_free_stays_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ownerQ == OWN_NONE && !tapClaimTrue && !busClaimTrue) |=> (ownerQ == OWN_NONE));

  p_hold_tap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ownerQ == OWN_TAP && !tapClaimWe) |=> (ownerQ == OWN_TAP));

  p_hold_bus_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ownerQ == OWN_BUS && !busClaimWe) |=> (ownerQ == OWN_BUS));

  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((ownerQ == OWN_TAP && tapDrop) || (ownerQ == OWN_BUS && busDrop)) |=> (ownerQ == OWN_NONE));

  p_single_owner_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.tapOwns, strobe.busOwns}));
endmodule

// File: rtl/trans_mutex_dp.sv
module trans_mutex_dp
  import trans_mutex_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mutexStrobe_t      strobe,
  input  logic              tapRegWe,
  input  logic [ADDR_W-1:0] tapRegAddr,
  input  logic [DATA_W-1:0] tapRegWdata,
  input  logic              busRegWe,
  input  logic [ADDR_W-1:0] busRegAddr,
  input  logic [DATA_W-1:0] busRegWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] tapRegRdata,
  output logic [DATA_W-1:0] busRegRdata
);
  localparam int SIDES = 2;  // index 0 = TAP, 1 = bus

  logic [SIDES-1:0]             sideOwns;
  logic [SIDES-1:0]             sideWe;
  logic [SIDES-1:0][ADDR_W-1:0] sideAddr;
  logic [SIDES-1:0][DATA_W-1:0] sideWdata;
  logic [SIDES-1:0][DATA_W-1:0] sideRdata;
  logic [SIDES-1:0]             sideSel;
  logic [SIDES-1:0][ADDR_W-1:0] addrTerm;
  logic [SIDES-1:0][DATA_W-1:0] dataTerm;

  assign sideOwns  = {strobe.busOwns, strobe.tapOwns};
  assign sideWe    = {busRegWe, tapRegWe};
  assign sideAddr  = {busRegAddr, tapRegAddr};
  assign sideWdata = {busRegWdata, tapRegWdata};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    assign sideRdata[s] = sideOwns[s] ? regRdata : '0;
    assign sideSel[s]   = sideOwns[s] && sideWe[s];
    assign addrTerm[s]  = sideOwns[s] ? sideAddr[s]  : '0;
    assign dataTerm[s]  = sideOwns[s] ? sideWdata[s] : '0;
  end

  assign regWe       = strobe.writeOpen && (|sideSel);
  assign regAddr     = addrTerm[0] | addrTerm[1];
  assign regWdata    = dataTerm[0] | dataTerm[1];
  assign tapRegRdata = sideRdata[0];
  assign busRegRdata = sideRdata[1];

  p_write_closed_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeOpen |-> !regWe);

  p_tap_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tapOwns |-> (tapRegRdata == '0));

  p_bus_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.busOwns |-> (busRegRdata == '0));

  p_no_foreign_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tapOwns && !tapRegWe) |-> !regWe);
endmodule

// File: rtl/trans_mutex.sv
module trans_mutex
  import trans_mutex_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              transBusy,
  input  logic              tapClaimWe,
  input  logic [7:0]        tapClaimWdata,
  output logic [7:0]        tapClaimRdata,
  output logic              tapRegwen,
  input  logic              tapRegWe,
  input  logic [ADDR_W-1:0] tapRegAddr,
  input  logic [DATA_W-1:0] tapRegWdata,
  output logic [DATA_W-1:0] tapRegRdata,
  input  logic              busClaimWe,
  input  logic [7:0]        busClaimWdata,
  output logic [7:0]        busClaimRdata,
  output logic              busRegwen,
  input  logic              busRegWe,
  input  logic [ADDR_W-1:0] busRegAddr,
  input  logic [DATA_W-1:0] busRegWdata,
  output logic [DATA_W-1:0] busRegRdata,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  mutexStrobe_t strobe;

  trans_mutex_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .transBusy(transBusy),
    .tapClaimWe(tapClaimWe), .tapClaimWdata(tapClaimWdata),
    .busClaimWe(busClaimWe), .busClaimWdata(busClaimWdata),
    .strobe(strobe),
    .tapClaimRdata(tapClaimRdata), .busClaimRdata(busClaimRdata),
    .tapRegwen(tapRegwen), .busRegwen(busRegwen)
  );

  trans_mutex_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tapRegWe(tapRegWe), .tapRegAddr(tapRegAddr), .tapRegWdata(tapRegWdata),
    .busRegWe(busRegWe), .busRegAddr(busRegAddr), .busRegWdata(busRegWdata),
    .regRdata(regRdata),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .tapRegRdata(tapRegRdata), .busRegRdata(busRegRdata)
  );
endmodule

// File: tb/test_trans_mutex.sv
module test_trans_mutex;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic transBusy = 1'b0;
  logic tapClaimWe = 1'b0, busClaimWe = 1'b0;
  logic [7:0] tapClaimWdata = '0, busClaimWdata = '0;
  logic [7:0] tapClaimRdata, busClaimRdata;
  logic tapRegwen, busRegwen;
  logic tapRegWe = 1'b0, busRegWe = 1'b0;
  logic [AW-1:0] tapRegAddr = '0, busRegAddr = '0;
  logic [DW-1:0] tapRegWdata = '0, busRegWdata = '0, regRdata = '0;
  logic [DW-1:0] tapRegRdata, busRegRdata, regWdata;
  logic regWe;
  logic [AW-1:0] regAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  trans_mutex #(.DATA_W(DW), .ADDR_W(AW)) i_trans_mutex (
    .clk(clk), .rstN(rstN), .transBusy(transBusy),
    .tapClaimWe(tapClaimWe), .tapClaimWdata(tapClaimWdata),
    .tapClaimRdata(tapClaimRdata), .tapRegwen(tapRegwen),
    .tapRegWe(tapRegWe), .tapRegAddr(tapRegAddr), .tapRegWdata(tapRegWdata),
    .tapRegRdata(tapRegRdata),
    .busClaimWe(busClaimWe), .busClaimWdata(busClaimWdata),
    .busClaimRdata(busClaimRdata), .busRegwen(busRegwen),
    .busRegWe(busRegWe), .busRegAddr(busRegAddr), .busRegWdata(busRegWdata),
    .busRegRdata(busRegRdata),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  typedef struct packed {
    logic       tWe;
    logic [7:0] tData;
    logic       bWe;
    logic [7:0] bData;
    logic [7:0] expTap;
    logic [7:0] expBus;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 1'b0, 8'h00, 8'h69, 8'h69},  // idle stays free (R3)
    '{1'b1, 8'h96, 1'b1, 8'h96, 8'h96, 8'h69},  // simultaneous, TAP wins (R4)
    '{1'b0, 8'h00, 1'b1, 8'h96, 8'h96, 8'h69},  // bus claim ignored (R5)
    '{1'b1, 8'h00, 1'b0, 8'h00, 8'h69, 8'h69},  // owner writes 0 (R6)
    '{1'b0, 8'h00, 1'b1, 8'h5A, 8'h69, 8'h69},  // bad code (R3)
    '{1'b0, 8'h00, 1'b1, 8'h69, 8'h69, 8'h69},  // false code (R3)
    '{1'b0, 8'h00, 1'b1, 8'h96, 8'h69, 8'h96},  // bus claims (R2)
    '{1'b1, 8'h96, 1'b0, 8'h00, 8'h69, 8'h96},  // tap claim ignored (R5)
    '{1'b0, 8'h00, 1'b1, 8'h69, 8'h69, 8'h69},  // owner writes false (R6)
    '{1'b1, 8'h97, 1'b0, 8'h00, 8'h69, 8'h69},  // near-miss code (R3)
    '{1'b1, 8'h96, 1'b0, 8'h00, 8'h96, 8'h69},  // tap claims (R2)
    '{1'b1, 8'h3C, 1'b0, 8'h00, 8'h69, 8'h69}   // owner writes other (R6)
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic claimStep(input logic tWe, input logic [7:0] tD,
                           input logic bWe, input logic [7:0] bD);
    tapClaimWe = tWe; tapClaimWdata = tD;
    busClaimWe = bWe; busClaimWdata = bD;
    @(posedge clk); #1;
    tapClaimWe = 1'b0; busClaimWe = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 claimRd", {tapClaimRdata, busClaimRdata}, {8'h69, 8'h69});
    check("R1 regwen", {tapRegwen, busRegwen, regWe}, 3'b000);
    check("R1 addr/data", {regAddr, regWdata}, '0);
    rstN = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      claimStep(VEC[i].tWe, VEC[i].tData, VEC[i].bWe, VEC[i].bData);
      check($sformatf("R2..R6 row %0d claimRd", i),
            {tapClaimRdata, busClaimRdata}, {VEC[i].expTap, VEC[i].expBus});
      check($sformatf("R2 row %0d regwen", i), {tapRegwen, busRegwen},
            {VEC[i].expTap == 8'h96, VEC[i].expBus == 8'h96});
    end

    // R7 / R8 with TAP owning
    claimStep(1'b1, 8'h96, 1'b0, 8'h00);
    regRdata = 32'hDEAD_BEEF; #1;
    check("R7 tap owner read", tapRegRdata, 32'hDEAD_BEEF);
    check("R7 bus masked", busRegRdata, 32'h0);
    tapRegWe = 1'b1; tapRegAddr = 4'd3; tapRegWdata = 32'h1234;
    busRegWe = 1'b1; busRegAddr = 4'd5; busRegWdata = 32'h5555; #1;
    check("R8 owner write", {regWe, regAddr, regWdata}, {1'b1, 4'd3, 32'h1234});
    tapRegWe = 1'b0; #1;
    check("R8 non-owner write dropped", regWe, 1'b0);
    // R9 busy gating
    tapRegWe = 1'b1; transBusy = 1'b1; #1;
    check("R9 we blocked", {regWe, tapRegwen}, 2'b00);
    @(posedge clk); #1;
    transBusy = 1'b0; #1;
    check("R9 ownership kept", {tapClaimRdata, tapRegwen, regWe}, {8'h96, 1'b1, 1'b1});
    tapRegWe = 1'b0; busRegWe = 1'b0;

    // R7 with bus owning
    claimStep(1'b1, 8'h00, 1'b0, 8'h00);
    claimStep(1'b0, 8'h00, 1'b1, 8'h96);
    regRdata = 32'hCAFE_0001; #1;
    check("R7 bus owner read", busRegRdata, 32'hCAFE_0001);
    check("R7 tap masked", tapRegRdata, 32'h0);
    busRegWe = 1'b1; busRegAddr = 4'd9; busRegWdata = 32'hA5A5; #1;
    check("R8 bus owner write", {regWe, regAddr, regWdata}, {1'b1, 4'd9, 32'hA5A5});
    busRegWe = 1'b0;

    // R1 reset while owned
    rstN = 1'b0; #1;
    check("R1 reset releases", {tapClaimRdata, busClaimRdata, busRegRdata},
          {8'h69, 8'h69, 32'h0});
    @(posedge clk); #1;
    rstN = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule